// File: doc/BRIEF.md
# Programmable Interface State Sequencer

This block runs an external bus interface from a state graph held in a loadable descriptor RAM, so the graph is not fixed in logic. Each of up to 256 states has a 256-bit descriptor. The descriptor names the actions the state asserts and two exit transitions. Each exit transition is guarded by a programmable condition over trigger inputs, which are a mix of external pin levels and internal status flags. A host loads the descriptors one 32-bit word at a time while the engine is stopped. A start pulse then sets the engine running from state 0.

On every clock cycle the engine looks up the descriptor of the current state. It evaluates both exit conditions and drives the action vector, whose bits are control pin levels and buffer read/write strobes. The first exit has priority over the second. If neither exit holds, the engine stays in the current state. A state can also request a dwell time, during which its exits are not examined.

Top module: `seq_engine`

## Requirements
- R1: After a synchronous reset the engine is stopped (`running`=0) with `state`=0 and `act`=0. It stays that way, whatever the triggers, until `start` is pulsed.
- R2: A write with `wr_en`=1 stores `wr_data` into word `wr_addr[2:0]` of state `wr_addr[10:3]`. The word layout is as follows. Word 0 holds exit-0 target in [7:0], exit-1 target in [15:8] and dwell enable in [16]. Word 1 holds the exit-0 table in [15:0] and the exit-1 table in [31:16]. Word 2 holds the exit-0 selects and word 3 the exit-1 selects, four 5-bit fields each, with the select for index bit k in bits [5k+4:5k]. Word 4 holds the dwell count in [15:0]. Word 5 holds the action mask in [15:0] and the repeat mask in [31:16]. Words 6 and 7 are reserved.
- R3: A descriptor write made while `running`=1 is ignored.
- R4: An exit condition is true when bit i of its 16-bit table is 1, where i = {trig[s3],trig[s2],trig[s1],trig[s0]} and s0 to s3 are its four select fields.
- R5: When exit 0's condition is true while running, `state` takes the exit-0 target on the next clock edge.
- R6: Exit 1 is taken on the next clock edge only when exit 0's condition is false and exit 1's condition is true.
- R7: When both conditions are false, `state` is unchanged on the next edge and both conditions are evaluated again.
- R8: With dwell enabled and count N, both conditions are ignored until the state has been held for N cycles. The entry cycle counts as cycle 0, so the earliest transition is at the edge ending cycle N. A taken transition, including one back to the same state, restarts the count.
- R9: An action bit whose repeat-mask bit is 1 is asserted on every cycle spent in the state. An action bit whose repeat-mask bit is 0 is asserted only in the entry cycle.
- R10: `start` while stopped sets the engine running in state 0, and that cycle counts as an entry cycle. `start` while running is ignored.
- R11: A reset while running returns the engine to the stopped state with `state`=0 and `act`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, honoured only while stopped |
| wr_en | input | 1 | Descriptor word write enable |
| wr_addr | input | 11 | {state index, word index} |
| wr_data | input | 32 | Descriptor word |
| trig | input | 32 | Trigger vector (pins and internal flags) |
| running | output | 1 | Engine is executing the graph |
| state | output | 8 | Current state index |
| act | output | 16 | Action outputs (pin levels and strobes) |

## Verification
A wrong truth-table index, select decode or exit priority sends the engine to the wrong state. This shows on `state` at the first clock edge after the triggers are applied, so the bench sweeps all sixteen index values with select patterns whose order matters. A dwell counter that is off by one moves the transition one edge early or late, and the bench checks the state at every edge of the window. A lost entry flag makes once-actions stick or vanish, which shows on `act` one cycle after entry. A write that leaks in while running changes a later transition.

// File: rtl/seq_pkg.sv
package seq_pkg;

   localparam int WORD_W     = 32;
   localparam int USED_WORDS = 6;
   localparam int RAW_W      = WORD_W * USED_WORDS;

   typedef struct packed {
      logic [15:0]      rep;
      logic [15:0]      act;
      logic [15:0]      dwell;
      logic [3:0][4:0]  sel1;
      logic [3:0][4:0]  sel0;
      logic [15:0]      tt1;
      logic [15:0]      tt0;
      logic             dwell_en;
      logic [7:0]       tgt1;
      logic [7:0]       tgt0;
   } desc_t;

   function automatic desc_t unpack_desc(input logic [RAW_W-1:0] raw);
      desc_t d;
      d.tgt0     = raw[7:0];
      d.tgt1     = raw[15:8];
      d.dwell_en = raw[16];
      d.tt0      = raw[32+:16];
      d.tt1      = raw[48+:16];
      d.sel0     = raw[64+:20];
      d.sel1     = raw[96+:20];
      d.dwell    = raw[128+:16];
      d.act      = raw[160+:16];
      d.rep      = raw[176+:16];
      return d;
   endfunction

endpackage

// File: rtl/seq_desc_ram.sv
module seq_desc_ram #(
   parameter int DEPTH  = 256,
   parameter int ADDR_W = 8,
   parameter int LANES  = 6,
   parameter int WORD_W = 32
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [ADDR_W+2:0]         waddr,
   input  logic [WORD_W-1:0]         wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [LANES*WORD_W-1:0]   rdata
);

   if (DEPTH != (1 << ADDR_W)) begin : g_bad_depth
      $error("seq_desc_ram: DEPTH must equal 2**ADDR_W");
   end
   if (LANES > 8) begin : g_bad_lanes
      $error("seq_desc_ram: at most 8 words per descriptor");
   end

   // One word-wide array per descriptor word; reserved words have no storage.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [WORD_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && (waddr[2:0] == 3'(g)))
            mem[waddr[ADDR_W+2:3]] <= wdata;
      end

      assign rdata[g*WORD_W +: WORD_W] = mem[raddr];
   end

endmodule

// File: rtl/seq_cond.sv
module seq_cond #(
   parameter int TRIG_W = 32
) (
   input  logic [TRIG_W-1:0] trig,
   input  logic [3:0][4:0]   sel,
   input  logic [15:0]       table_bits,
   output logic              hit
);

   localparam int SEL_W = $clog2(TRIG_W);

   if (SEL_W > 5 || (1 << SEL_W) != TRIG_W) begin : g_bad_trig
      $error("seq_cond: TRIG_W must be a power of two up to 32");
   end

   logic [3:0] idx;

   for (genvar k = 0; k < 4; k++) begin : g_pick
      assign idx[k] = trig[sel[k][SEL_W-1:0]];
   end

   assign hit = table_bits[idx];

endmodule

// File: rtl/seq_engine.sv
module seq_engine #(
   parameter int STATE_W = 8,
   parameter int TRIG_W  = 32,
   parameter int ACT_W   = 16,
   parameter int CNT_W   = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic                 wr_en,
   input  logic [STATE_W+2:0]   wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [TRIG_W-1:0]    trig,
   output logic                 running,
   output logic [STATE_W-1:0]   state,
   output logic [ACT_W-1:0]     act
);
   import seq_pkg::*;

   localparam int NSTATES = 1 << STATE_W;

   if (STATE_W > 8 || STATE_W < 1) begin : g_bad_state
      $error("seq_engine: STATE_W must be 1..8");
   end
   if (ACT_W > 16 || CNT_W > 16 || CNT_W < 1) begin : g_bad_width
      $error("seq_engine: ACT_W and CNT_W limited to 16");
   end

   logic                running_q;
   logic [STATE_W-1:0]  state_q;
   logic                first_q;
   logic [CNT_W-1:0]    cnt_q;

   logic [RAW_W-1:0]    raw;
   desc_t               d;
   logic [1:0]          hit;
   logic                eval_ok;
   logic [STATE_W-1:0]  tgt0, tgt1;
   logic [ACT_W-1:0]    act_mask, rep_mask;
   logic [CNT_W-1:0]    dwell_n;

   seq_desc_ram #(
      .DEPTH (NSTATES),
      .ADDR_W(STATE_W),
      .LANES (USED_WORDS),
      .WORD_W(WORD_W)
   ) u_ram (
      .clk  (clk),
      .we   (wr_en && !running_q),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(state_q),
      .rdata(raw)
   );

   assign d        = unpack_desc(raw);
   assign tgt0     = d.tgt0[STATE_W-1:0];
   assign tgt1     = d.tgt1[STATE_W-1:0];
   assign act_mask = d.act[ACT_W-1:0];
   assign rep_mask = d.rep[ACT_W-1:0];
   assign dwell_n  = d.dwell[CNT_W-1:0];

   for (genvar k = 0; k < 2; k++) begin : g_exit
      seq_cond #(.TRIG_W(TRIG_W)) u_cond (
         .trig      (trig),
         .sel       ((k == 0) ? d.sel0 : d.sel1),
         .table_bits((k == 0) ? d.tt0  : d.tt1),
         .hit       (hit[k])
      );
   end

   assign eval_ok = !d.dwell_en || (cnt_q >= dwell_n);

   always_ff @(posedge clk) begin
      if (rst) begin
         running_q <= 1'b0;
         state_q   <= '0;
         first_q   <= 1'b0;
         cnt_q     <= '0;
      end else if (!running_q) begin
         if (start) begin
            running_q <= 1'b1;
            state_q   <= '0;
            first_q   <= 1'b1;
            cnt_q     <= '0;
         end
      end else if (eval_ok && hit[0]) begin
         state_q <= tgt0;
         first_q <= 1'b1;
         cnt_q   <= '0;
      end else if (eval_ok && hit[1]) begin
         state_q <= tgt1;
         first_q <= 1'b1;
         cnt_q   <= '0;
      end else begin
         first_q <= 1'b0;
         if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign running = running_q;
   assign state   = state_q;
   assign act     = running_q ? (act_mask & (rep_mask | {ACT_W{first_q}})) : '0;

   // Stopped engine sits in state 0 (R1, R11)
   p_idle_state_r1: assert property (@(posedge clk) disable iff (rst)
      !running_q |-> (state_q == '0 && act == '0));

   // Exit 0 wins whenever its condition holds (R5)
   p_exit0_prio_r5: assert property (@(posedge clk) disable iff (rst)
      (running_q && eval_ok && hit[0]) |=> (state_q == $past(tgt0)));

   // Exit 1 only when exit 0 fails (R6)
   p_exit1_r6: assert property (@(posedge clk) disable iff (rst)
      (running_q && eval_ok && !hit[0] && hit[1]) |=> (state_q == $past(tgt1)));

   // No exit true: state held (R7)
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (running_q && eval_ok && !hit[0] && !hit[1]) |=> $stable(state_q));

   // Dwell window blocks every exit (R8)
   p_dwell_block_r8: assert property (@(posedge clk) disable iff (rst)
      (running_q && d.dwell_en && (cnt_q < dwell_n)) |=> $stable(state_q) && !first_q);

   // Once-actions vanish after the entry cycle (R9)
   p_once_r9: assert property (@(posedge clk) disable iff (rst)
      (running_q && !first_q) |-> ((act & ~rep_mask) == '0));

   // Start while running has no effect on the state (R10)
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
      (running_q && start && !(eval_ok && (hit[0] || hit[1]))) |=> $stable(state_q));

endmodule

// File: tb/tb_seq_engine.sv
module tb_seq_engine;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        start;
   logic        wr_en;
   logic [10:0] wr_addr;
   logic [31:0] wr_data;
   logic [31:0] trig;
   logic        running;
   logic [7:0]  state;
   logic [15:0] act;

   int n_tests = 0;
   int n_fail  = 0;

   localparam logic [15:0] TT0 = 16'hA5C3;
   localparam logic [15:0] TT1 = 16'h3C5A;

   always #(CLK_PERIOD/2) clk = ~clk;

   seq_engine dut (
      .clk(clk), .rst(rst), .start(start), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .trig(trig),
      .running(running), .state(state), .act(act)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
      n_tests++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, actual, expected);
      end
   endtask

   function automatic logic [255:0] mk(
      input logic [7:0] t0, input logic [7:0] t1, input logic den,
      input logic [15:0] ta, input logic [15:0] tb,
      input logic [19:0] sa, input logic [19:0] sb,
      input logic [15:0] dw, input logic [15:0] ac, input logic [15:0] rp);
      logic [255:0] r;
      r = '0;
      r[7:0] = t0; r[15:8] = t1; r[16] = den;
      r[32+:16] = ta; r[48+:16] = tb;
      r[64+:20] = sa; r[96+:20] = sb;
      r[128+:16] = dw;
      r[160+:16] = ac; r[176+:16] = rp;
      return r;
   endfunction

   task automatic put_word(input logic [7:0] s, input logic [2:0] w, input logic [31:0] v);
      wr_en = 1'b1; wr_addr = {s, w}; wr_data = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [7:0] s, input logic [255:0] r);
      for (int w = 0; w < 8; w++) put_word(s, 3'(w), r[w*32 +: 32]);
   endtask

   function automatic logic [31:0] trig_of(input logic [3:0] c);
      logic [31:0] t;
      t = 32'h0F0F_0000;
      t[4] = c[0]; t[9] = c[1]; t[20] = c[2]; t[31] = c[3];
      return t;
   endfunction

   task automatic restart(input logic [31:0] t);
      rst = 1'b1; tick();
      rst = 1'b0; start = 1'b1; trig = t; tick();
      start = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] rev;
      logic       f0, f1;
      logic [7:0] nxt;
      int         c2;

      rst = 1'b1; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; trig = '1;
      @(negedge clk);
      tick();
      rst = 1'b0;
      // R1: idle after reset, triggers ignored
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R1 running", {31'd0, running}, 32'd0);
         chk("R1 state", {24'd0, state}, 32'd0);
         chk("R1 act", {16'd0, act}, 32'd0);
      end

      // R2: load graph while stopped
      load(8'd0, mk(8'd1, 8'd2, 1'b0, TT0, TT1,
                    {5'd31, 5'd20, 5'd9, 5'd4}, {5'd4, 5'd9, 5'd20, 5'd31},
                    16'd0, 16'h00FF, 16'h000F));
      load(8'd1, mk(8'd5, 8'd5, 1'b0, 16'h0, 16'h0, 20'd0, 20'd0, 16'd0, 16'h0100, 16'h0000));
      load(8'd2, mk(8'd3, 8'd3, 1'b0, 16'hFFFF, 16'h0, 20'd0, 20'd0, 16'd0, 16'h0000, 16'h0000));
      load(8'd3, mk(8'd4, 8'd6, 1'b1, 16'hFFFF, 16'hFFFF, 20'd0, 20'd0, 16'd5, 16'h0000, 16'h0000));
      load(8'd4, mk(8'd7, 8'd7, 1'b0, 16'h0, 16'h0, 20'd0, 20'd0, 16'd0, 16'h8000, 16'h8000));

      // R4 R5 R6 R7 R9 R10: sweep all index values
      for (int c = 0; c < 16; c++) begin
         rev = {c[0], c[1], c[2], c[3]};
         f0 = TT0[c];
         f1 = TT1[rev];
         nxt = f0 ? 8'd1 : (f1 ? 8'd2 : 8'd0);
         restart(trig_of(4'(c)));
         chk("R10 start entry", {31'd0, running}, 32'd1);
         chk("R9 entry act", {16'd0, act}, 32'h00FF);
         tick();
         chk("R4 R5 R6 R7 next state", {24'd0, state}, {24'd0, nxt});
         if (nxt == 8'd0) chk("R9 repeat act", {16'd0, act}, 32'h000F);
      end

      // R9 R7: once-action in state 1
      restart(trig_of(4'd0));
      tick();
      chk("R5 to state 1", {24'd0, state}, 32'd1);
      chk("R9 once entry", {16'd0, act}, 32'h0100);
      tick();
      chk("R9 once cleared", {16'd0, act}, 32'h0000);
      chk("R7 hold", {24'd0, state}, 32'd1);

      // R3: write while running ignored
      put_word(8'd1, 3'd1, 32'hFFFF_FFFF);
      tick(); tick();
      chk("R3 write ignored", {24'd0, state}, 32'd1);

      // R10: start while running ignored
      start = 1'b1; tick(); start = 1'b0; tick();
      chk("R10 start ignored", {24'd0, state}, 32'd1);

      // R11: reset mid-run
      rst = 1'b1; tick();
      chk("R11 running", {31'd0, running}, 32'd0);
      chk("R11 state", {24'd0, state}, 32'd0);
      chk("R11 act", {16'd0, act}, 32'd0);
      rst = 1'b0;

      // R8: dwell window via state 2 -> 3 -> 4
      c2 = -1;
      for (int c = 0; c < 16; c++) begin
         rev = {c[0], c[1], c[2], c[3]};
         if (c2 < 0 && !TT0[c] && TT1[rev]) c2 = c;
      end
      restart(trig_of(4'(c2)));
      tick();
      chk("R6 to state 2", {24'd0, state}, 32'd2);
      tick();
      chk("R8 enter dwell state", {24'd0, state}, 32'd3);
      for (int k = 1; k <= 5; k++) begin
         tick();
         chk("R8 dwell hold", {24'd0, state}, 32'd3);
      end
      tick();
      chk("R8 dwell exit", {24'd0, state}, 32'd4);
      chk("R9 repeat entry", {16'd0, act}, 32'h8000);
      tick();
      chk("R9 repeat held", {16'd0, act}, 32'h8000);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule